// File: doc/BRIEF.md
# Indirect Transfer FIFO Controller

This block runs a single indirect transfer between a serial flash engine and a local word-wide FIFO that a host empties or fills through a trigger window. Software loads a flash start address, a total byte count and an address length, then writes a control word that carries a start bit and a direction bit. For a read, the controller asks the flash engine for one word at a time while the FIFO has space, pads the last partial word, and the host pops words out. For a write, the host pushes words into the FIFO and the controller hands each one to the flash engine with its count of valid bytes.

Progress is visible through a status word (in-progress, sticky done, latched direction) and a fill-level word that reports the FIFO occupancy in words, the read level in the low half and the write level in the high half. A cancel bit aborts the transfer at any point and empties the FIFO. The flash engine accepts a request with a ready handshake and, for reads, returns its data word in the same cycle as it accepts.

Top module: `ixf_ctrl`

## Requirements
- R1: After reset the status word and the fill-level word read zero and no flash request is raised.
- R2: A control write (reg_sel 0) with bit 0 set starts a transfer in the direction given by bit 8 (0 read, 1 write); in-progress (status bit 2) reads one in the cycle after the write, and a start written while a transfer is in progress is ignored, as are changes to the address and count registers (reg_sel 1 and 2) made then.
- R3: Flash requests carry consecutive word addresses from the programmed start address, stepping by the word width, each with a valid byte count equal to the smaller of the word width and the bytes still owed.
- R4: During a read, no flash request is raised while the FIFO holds its full depth of words.
- R5: In the final partial word of a read, byte lanes at or above the valid byte count are delivered as zero; lane i occupies bits 8i+7 down to 8i.
- R6: The fill-level word reports the FIFO occupancy in words in bits 15:0 during a read and in bits 31:16 during a write; the other half reads zero.
- R7: During a write, host pushes are accepted while the FIFO is not full and the flash engine receives the pushed words in order with the write flag set.
- R8: Done (status bit 5) sets when all bytes have been requested and, for a read, the FIFO has been drained; in-progress clears in that same cycle, and a zero byte count completes one cycle after it starts.
- R9: Done stays set until a control write with bit 5 set; a control write with bit 5 clear leaves it set.
- R10: A control write with bit 1 set aborts the transfer: in-progress and done read zero, the FIFO is emptied and no further request is raised; cancel takes precedence over a start in the same write.
- R11: The address length register (reg_sel 3, bits 3:0) holds the address byte count minus one; request address bytes above that count are driven as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 start address, 2 byte count, 3 address length |
| reg_wdata | input | 32 | Register write data |
| ctrl_status | output | 32 | Status: bit 2 in-progress, bit 5 done, bit 8 direction |
| fill_level | output | 32 | FIFO level in words: read level 15:0, write level 31:16 |
| host_push | input | 1 | Host pushes a word (write transfers) |
| host_wdata | input | 32 | Word pushed by the host |
| host_pop | input | 1 | Host pops a word (read transfers) |
| host_rdata | output | 32 | Word at the FIFO head |
| req_valid | output | 1 | Flash request valid |
| req_write | output | 1 | Request is a flash write |
| req_addr | output | 32 | Flash byte address, masked to the address length |
| req_nbytes | output | 3 | Valid bytes in this request |
| req_wdata | output | 32 | Write data for the request |
| req_ready | input | 1 | Flash engine accepts the request |
| rsp_rdata | input | 32 | Read data returned with acceptance |

## Verification
The bench builds the block with a four-byte word, an eight-word FIFO and a 32-bit address. The shallow FIFO lets a stalled host fill it within a few cycles, so the full-FIFO hold-off and a flush of a full FIFO are reached directly, while byte counts that are not multiples of four bring in padded final words. A 32-bit address allows every address length from one to four bytes, so each masking pattern is exercised against random start addresses.

// File: rtl/ixf_pkg.sv
package ixf_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_ADDR  = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_ALEN  = 2'd3
    } ixf_sel_e;

    localparam int CTL_START  = 0;
    localparam int CTL_CANCEL = 1;
    localparam int CTL_BUSY   = 2;
    localparam int CTL_DONE   = 5;
    localparam int CTL_DIR    = 8;

    localparam int LVL_W  = 16;
    localparam int ALEN_W = 4;

    typedef struct packed {
        logic start;
        logic cancel;
        logic clr_done;
        logic dir_wr;
    } ixf_cmd_t;

    function automatic ixf_cmd_t decode_cmd(input logic [31:0] w);
        ixf_cmd_t c;
        c.start    = w[CTL_START];
        c.cancel   = w[CTL_CANCEL];
        c.clr_done = w[CTL_DONE];
        c.dir_wr   = w[CTL_DIR];
        return c;
    endfunction

endpackage

// File: rtl/ixf_fifo.sv
module ixf_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (do_pop)  rd_ptr <= nxt(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_FIFO_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH)) else $error("fifo count above depth"); // R4

    AST_FIFO_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty) else $error("flush left data"); // R10

endmodule

// File: rtl/ixf_seq.sv
module ixf_seq
    import ixf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int WB     = 4,
    parameter int NB_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  ixf_cmd_t          cmd,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  byte_cnt,
    input  logic              fifo_empty,
    input  logic              fifo_full,
    input  logic              req_ready,
    output logic              busy,
    output logic              done,
    output logic              dir_wr,
    output logic              req_valid,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [NB_W-1:0]   step_bytes,
    output logic              fire,
    output logic              flush
);
    localparam logic [CNT_W-1:0] WB_C = CNT_W'(WB);

    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] step;
    logic             finish;
    logic             accept_start;

    assign step         = (remain < WB_C) ? remain : WB_C;
    assign step_bytes   = step[NB_W-1:0];
    assign req_valid    = busy && (remain != '0) && (dir_wr ? !fifo_empty : !fifo_full);
    assign fire         = req_valid && req_ready;
    assign finish       = busy && (remain == '0) && (dir_wr || fifo_empty);
    assign accept_start = cmd_valid && cmd.start && !cmd.cancel && !busy;
    assign flush        = cmd_valid && (cmd.cancel || accept_start);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            dir_wr   <= 1'b0;
            remain   <= '0;
            cur_addr <= '0;
        end else if (cmd_valid && cmd.cancel) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            remain <= '0;
        end else if (accept_start) begin
            busy     <= 1'b1;
            done     <= 1'b0;
            dir_wr   <= cmd.dir_wr;
            remain   <= byte_cnt;
            cur_addr <= start_addr;
        end else begin
            if (fire) begin
                remain   <= remain - step;
                cur_addr <= cur_addr + ADDR_W'(WB);
            end
            if (cmd_valid && cmd.clr_done) done <= 1'b0;
            if (finish) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(busy && done)) else $error("busy and done together"); // R8

    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(cmd_valid && cmd.cancel)) |-> done)
        else $error("busy fell without done"); // R8

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
        accept_start |=> busy) else $error("start did not raise busy"); // R2

    AST_CANCEL_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd.cancel) |=> (!busy && !done && !req_valid))
        else $error("cancel left activity"); // R10

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (done && !cmd_valid) |=> done) else $error("done dropped"); // R9

    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (step_bytes != '0 && step_bytes <= NB_W'(WB)))
        else $error("bad step"); // R3

endmodule

// File: rtl/ixf_ctrl.sv
module ixf_ctrl
    import ixf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int WB     = 4,
    parameter int DEPTH  = 8,
    parameter int DW     = 8 * WB,
    parameter int NB_W   = $clog2(WB + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       ctrl_status,
    output logic [31:0]       fill_level,
    input  logic              host_push,
    input  logic [DW-1:0]     host_wdata,
    input  logic              host_pop,
    output logic [DW-1:0]     host_rdata,
    output logic              req_valid,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [NB_W-1:0]   req_nbytes,
    output logic [DW-1:0]     req_wdata,
    input  logic              req_ready,
    input  logic [DW-1:0]     rsp_rdata
);
    localparam int AB = ADDR_W / 8;
    localparam int CW = $clog2(DEPTH + 1);

    logic [ADDR_W-1:0] start_addr_q;
    logic [CNT_W-1:0]  byte_cnt_q;
    logic [ALEN_W-1:0] alen_q;

    logic              cmd_valid;
    ixf_cmd_t          cmd;
    logic              busy, done, dir_wr, fire, flush;
    logic [ADDR_W-1:0] cur_addr;
    logic [NB_W-1:0]   step_bytes;

    logic              f_push, f_pop, f_full, f_empty;
    logic [DW-1:0]     f_wdata, f_rdata, padded;
    logic [CW-1:0]     f_count;

    assign cmd_valid = reg_wr && (ixf_sel_e'(reg_sel) == SEL_CTRL);
    assign cmd       = decode_cmd(reg_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_addr_q <= '0;
            byte_cnt_q   <= '0;
            alen_q       <= '0;
        end else if (reg_wr) begin
            case (ixf_sel_e'(reg_sel))
                SEL_ADDR:  start_addr_q <= reg_wdata[ADDR_W-1:0];
                SEL_COUNT: byte_cnt_q   <= reg_wdata[CNT_W-1:0];
                SEL_ALEN:  alen_q       <= reg_wdata[ALEN_W-1:0];
                default:   ;
            endcase
        end
    end

    ixf_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WB(WB), .NB_W(NB_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd        (cmd),
        .start_addr (start_addr_q),
        .byte_cnt   (byte_cnt_q),
        .fifo_empty (f_empty),
        .fifo_full  (f_full),
        .req_ready  (req_ready),
        .busy       (busy),
        .done       (done),
        .dir_wr     (dir_wr),
        .req_valid  (req_valid),
        .cur_addr   (cur_addr),
        .step_bytes (step_bytes),
        .fire       (fire),
        .flush      (flush)
    );

    for (genvar i = 0; i < WB; i++) begin : g_pad
        assign padded[8*i +: 8] = (32'(i) < 32'(step_bytes)) ? rsp_rdata[8*i +: 8] : 8'h00;
    end

    assign f_push  = dir_wr ? (busy && host_push) : fire;
    assign f_pop   = dir_wr ? fire : (busy && host_pop);
    assign f_wdata = dir_wr ? host_wdata : padded;

    ixf_fifo #(.W(DW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (flush),
        .push  (f_push),
        .wdata (f_wdata),
        .pop   (f_pop),
        .rdata (f_rdata),
        .count (f_count),
        .full  (f_full),
        .empty (f_empty)
    );

    for (genvar b = 0; b < AB; b++) begin : g_amask
        assign req_addr[8*b +: 8] = (32'(b) <= 32'(alen_q)) ? cur_addr[8*b +: 8] : 8'h00;
    end

    assign req_write  = dir_wr;
    assign req_nbytes = step_bytes;
    assign req_wdata  = f_rdata;
    assign host_rdata = f_rdata;

    always_comb begin
        ctrl_status           = '0;
        ctrl_status[CTL_BUSY] = busy;
        ctrl_status[CTL_DONE] = done;
        ctrl_status[CTL_DIR]  = dir_wr;
        fill_level            = '0;
        if (dir_wr) fill_level[31:16] = LVL_W'(f_count);
        else        fill_level[15:0]  = LVL_W'(f_count);
    end

    AST_RD_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (rst)
        (fire && !req_write) |-> !f_full) else $error("read push into full fifo"); // R4

    AST_WR_POP_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
        (fire && req_write) |-> !f_empty) else $error("write request without data"); // R7

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        !ctrl_status[CTL_BUSY] |-> !req_valid) else $error("request while idle"); // R10

endmodule

// File: tb/ixf_ctrl_bench.sv
module ixf_ctrl_bench;
    localparam int WB    = 4;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] ctrl_status, fill_level;
    logic        host_push = 1'b0, host_pop = 1'b0;
    logic [31:0] host_wdata = '0, host_rdata;
    logic        req_valid, req_write, req_ready = 1'b0;
    logic [31:0] req_addr, req_wdata, rsp_rdata = '0;
    logic [2:0]  req_nbytes;

    int nvec = 0;
    int nerr = 0;
    bit ended = 0;

    always #2 clk = ~clk;

    ixf_ctrl u_ixf_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .ctrl_status(ctrl_status), .fill_level(fill_level),
        .host_push(host_push), .host_wdata(host_wdata), .host_pop(host_pop), .host_rdata(host_rdata),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_nbytes(req_nbytes),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog (R8) actual=hung expected=finished");
        summary();
    end

    function automatic logic [7:0] fbyte(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    function automatic logic [31:0] amask(input int alen);
        logic [31:0] m = '0;
        for (int b = 0; b < 4; b++) if (b <= alen) m[8*b +: 8] = 8'hFF;
        return m;
    endfunction

    function automatic int minb(input int r);
        return (r < WB) ? r : WB;
    endfunction

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic setup(input logic [31:0] a, input int cnt, input int alen);
        reg_write(2'd1, a);
        reg_write(2'd2, 32'(cnt));
        reg_write(2'd3, 32'(alen));
    endtask

    task automatic done_clear(input logic [31:0] exp_status);
        @(negedge clk);
        chk(ctrl_status == exp_status, "R9 done holds", ctrl_status, exp_status);
        reg_write(2'd0, 32'h0);
        chk(ctrl_status[5] == 1'b1, "R9 zero write keeps done", ctrl_status[5], 1);
        reg_write(2'd0, 32'h20);
        chk(ctrl_status[5] == 1'b0, "R9 clear done", ctrl_status[5], 0);
    endtask

    task automatic run_read(input logic [31:0] a, input int cnt, input int alen,
                            input int rdy_pct, input int pop_pct, input bit restart);
        logic [31:0] q[$];
        int rem = cnt;
        logic [31:0] ea = a;
        bit prev_busy;
        bit fin = 0;
        setup(a, cnt, alen);
        reg_write(2'd0, 32'h1);
        chk(ctrl_status[2] == 1'b1, "R2 busy after start", ctrl_status, 32'h4);
        if (restart) begin
            reg_write(2'd1, a ^ 32'h0000_1000);
            reg_write(2'd2, 32'(cnt + 12));
            reg_write(2'd0, 32'h1);
        end
        prev_busy = ctrl_status[2];
        for (int it = 0; it < 4000 && !fin; it++) begin
            if (ctrl_status[5]) begin
                fin = 1;
                chk(prev_busy && !ctrl_status[2], "R8 busy falls with done", ctrl_status, 32'h20);
            end else begin
                chk(fill_level[31:16] == 0 && fill_level[15:0] <= DEPTH, "R6 read level", fill_level, 0);
                host_pop = 1'b0;
                if (fill_level[15:0] > 0 && ($urandom % 100) < pop_pct) begin
                    if (q.size() > 0) begin
                        chk(host_rdata == q[0], (rem == 0 && q.size() == 1 && (cnt % WB) != 0) ? "R5 padded data" : "R3 read data",
                            host_rdata, q[0]);
                        void'(q.pop_front());
                    end else chk(0, "R3 unexpected data", host_rdata, 0);
                    host_pop = 1'b1;
                end
                req_ready = 1'b0;
                if (req_valid) begin
                    chk(fill_level[15:0] < DEPTH, "R4 no request when full", fill_level, DEPTH - 1);
                    chk(req_write == 1'b0, "R3 direction", req_write, 0);
                    chk(req_addr == (ea & amask(alen)), "R11 masked address", req_addr, ea & amask(alen));
                    chk(int'(req_nbytes) == minb(rem), "R3 byte count", req_nbytes, minb(rem));
                    if (($urandom % 100) < rdy_pct) begin
                        logic [31:0] raw = $urandom;
                        logic [31:0] exp = '0;
                        for (int i = 0; i < WB; i++) begin
                            if (i < minb(rem)) begin
                                raw[8*i +: 8] = fbyte(ea + 32'(i));
                                exp[8*i +: 8] = raw[8*i +: 8];
                            end
                        end
                        req_ready = 1'b1;
                        rsp_rdata = raw;
                        q.push_back(exp);
                        rem -= minb(rem);
                        ea += WB;
                    end
                end
                prev_busy = ctrl_status[2];
                @(negedge clk);
            end
        end
        host_pop = 1'b0; req_ready = 1'b0;
        chk(fin == 1, "R8 read completes", fin, 1);
        chk(rem == 0 && q.size() == 0, "R8 all bytes moved", rem, 0);
        chk(ctrl_status == 32'h20, "R8 read status", ctrl_status, 32'h20);
        chk(fill_level == 0, "R6 level empty", fill_level, 0);
        done_clear(32'h20);
    endtask

    task automatic run_write(input logic [31:0] a, input int cnt, input int alen,
                             input int rdy_pct, input int push_pct);
        logic [31:0] q[$];
        int rem = cnt;
        int words = (cnt + WB - 1) / WB;
        int pushed = 0;
        logic [31:0] ea = a;
        bit prev_busy;
        bit fin = 0;
        setup(a, cnt, alen);
        reg_write(2'd0, 32'h101);
        chk(ctrl_status[2] == 1'b1 && ctrl_status[8] == 1'b1, "R2 write busy", ctrl_status, 32'h104);
        prev_busy = 1'b1;
        for (int it = 0; it < 4000 && !fin; it++) begin
            if (ctrl_status[5]) begin
                fin = 1;
                chk(prev_busy && !ctrl_status[2], "R8 busy falls with done", ctrl_status, 32'h120);
            end else begin
                chk(fill_level[15:0] == 0 && fill_level[31:16] <= DEPTH, "R6 write level", fill_level, 0);
                req_ready = 1'b0;
                if (req_valid) begin
                    chk(req_write == 1'b1, "R7 write flag", req_write, 1);
                    chk(req_addr == (ea & amask(alen)), "R11 masked address", req_addr, ea & amask(alen));
                    chk(int'(req_nbytes) == minb(rem), "R3 byte count", req_nbytes, minb(rem));
                    if (q.size() > 0) chk(req_wdata == q[0], "R7 write data order", req_wdata, q[0]);
                    else chk(0, "R7 request without push", req_wdata, 0);
                    if (($urandom % 100) < rdy_pct) begin
                        req_ready = 1'b1;
                        void'(q.pop_front());
                        rem -= minb(rem);
                        ea += WB;
                    end
                end
                host_push = 1'b0;
                if (pushed < words && fill_level[31:16] < DEPTH && ($urandom % 100) < push_pct) begin
                    host_wdata = $urandom;
                    host_push = 1'b1;
                    q.push_back(host_wdata);
                    pushed++;
                end
                prev_busy = ctrl_status[2];
                @(negedge clk);
            end
        end
        host_push = 1'b0; req_ready = 1'b0;
        chk(fin == 1, "R8 write completes", fin, 1);
        chk(rem == 0, "R7 all bytes written", rem, 0);
        chk(ctrl_status == 32'h120, "R8 write status", ctrl_status, 32'h120);
        done_clear(32'h120);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ctrl_status == 0, "R1 status reset", ctrl_status, 0);
        chk(fill_level == 0, "R1 level reset", fill_level, 0);
        chk(req_valid == 0, "R1 no request", req_valid, 0);

        // directed: zero count, partial word, restart ignored, address masks
        run_read(32'h1000_0040, 0, 3, 100, 100, 0);
        run_read(32'hAB12_3450, 7, 2, 100, 100, 0);
        run_read(32'h7700_0100, 13, 0, 60, 50, 1);
        run_write(32'hC0DE_0200, 5, 1, 100, 100);

        // directed: FIFO fills with host stalled, then cancel together with start
        setup(32'h0000_2000, 64, 3);
        reg_write(2'd0, 32'h1);
        req_ready = 1'b1;
        repeat (20) @(negedge clk);
        req_ready = 1'b0;
        chk(fill_level[15:0] == DEPTH, "R4 fifo full", fill_level, DEPTH);
        chk(req_valid == 0, "R4 request held off", req_valid, 0);
        reg_write(2'd0, 32'h3);
        chk(ctrl_status[2] == 0 && ctrl_status[5] == 0, "R10 cancel status", ctrl_status, 0);
        chk(fill_level == 0, "R10 fifo flushed", fill_level, 0);
        repeat (4) @(negedge clk);
        chk(req_valid == 0 && ctrl_status[5] == 0, "R10 stays idle", ctrl_status, 0);

        for (int n = 0; n < 12; n++) begin
            run_read($urandom, 1 + ($urandom % 40), $urandom % 4, 30 + ($urandom % 70), 20 + ($urandom % 80), 0);
            run_write($urandom, 1 + ($urandom % 40), $urandom % 4, 30 + ($urandom % 70), 20 + ($urandom % 80));
        end
        summary();
    end
endmodule